// File: doc/BRIEF.md
# Strobe Delay Tap Calibration Engine

This block finds the passing window of a read-strobe delay tap and centres the tap inside it. After a start pulse it loads a starting tap and drives it on both byte-lane tap outputs. For each trial tap it waits a fixed settling time, then streams a fixed test pattern as indexed 32-bit words and asks an external checker, through a request/acknowledge handshake, whether the data read back matched. Each trial runs this compare pass twice.

The search first moves upward from the starting tap until a trial fails or a hard ceiling is reached. It then returns to the starting tap and moves downward until a trial fails or tap zero passes. The centre of the two bounds goes to lane 0 and the centre plus one goes to lane 1. A one-cycle done pulse marks the end, and the final taps stay on the outputs until the next start. The memory and the data comparison sit outside the block.

Top module: `tapcal_engine`

## Requirements
- R1: While a trial runs (pattern words streaming or a test request pending), both lane tap outputs carry the same trial tap.
- R2: Moving upward, a passing trial at a tap below 32 moves to tap+1; a passing trial at tap 32 or above records that tap as the upper bound and restarts the search downward from the starting tap (the starting tap is tried again).
- R3: Moving upward, a failing trial at tap t records t-1 as the upper bound (0 when t is 0) and restarts downward from the starting tap.
- R4: Moving downward, a failing trial at tap t records t+1 as the lower bound and ends the search; a passing trial at tap 0 records 0 as the lower bound and ends the search; any other passing trial moves to tap-1.
- R5: At the end, lane 0 gets floor((upper+lower)/2) and lane 1 gets that value plus one, held at 63 when the centre is 63; done_o is high for exactly one cycle, in the same cycle the final taps first appear.
- R6: A trial is two compare passes, each a full word stream followed by one handshake; a failure reported on the first pass ends the trial at once with no second pass, and a trial fails if either pass reports a failure.
- R7: A compare pass streams words with index 0 up to 4*GROUPS-1 in order, one per cycle; for index n with group g = n/4 and k = n mod 4, bits 15:0 of the word are all ones when bit 2k of g is set (else zeros) and bits 31:16 are all ones when bit 2k+1 of g is set (else zeros).
- R8: The first pattern word of a trial appears no sooner than 4 cycles after the tap outputs change; test_req_o rises after the last word of a pass and stays high until test_ack_i is seen high.
- R9: start_i is ignored while a calibration is in progress; the result is the one the first start asked for.
- R10: After reset both tap outputs are 0 and done_o, test_req_o and pat_valid_o are low; after a calibration the final taps stay unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a calibration when idle |
| init_tap_i | input | TAP_W (6) | Starting tap, sampled with the accepted start |
| lane0_tap_o | output | TAP_W (6) | Delay tap for byte lane 0 |
| lane1_tap_o | output | TAP_W (6) | Delay tap for byte lane 1 |
| test_req_o | output | 1 | Asks the checker for the verdict of the pass just streamed |
| test_ack_i | input | 1 | Checker verdict valid |
| test_fail_i | input | 1 | Checker verdict: 1 means mismatch, read with test_ack_i |
| pat_valid_o | output | 1 | A pattern word is on pat_word_o |
| pat_idx_o | output | IDX_W (10) | Word index within the pass |
| pat_word_o | output | WORD_W (32) | Pattern word |
| done_o | output | 1 | One-cycle pulse when the final taps are applied |

## Verification
A tap change takes effect at a rising edge, the settle count spans the next four edges, so the first pattern word of a trial is visible in the fifth cycle after the change and the words follow one per cycle. An acknowledge sampled high at a rising edge drops the request at that same edge, and done_o rises together with the final taps one cycle after the last verdict has been evaluated. The bench drives and samples only at falling edges, answers each request two cycles after seeing it, polls for done_o and checks the lanes in that same falling edge, then checks that done_o is gone one cycle later and that the taps hold for twenty more cycles.

// File: rtl/tapcal_pkg.sv
package tapcal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_STREAM,
    ST_REQ,
    ST_EVAL,
    ST_FINAL
  } cal_state_e;

endpackage

// File: rtl/tapcal_pattern_gen.sv
// Word stream for one compare pass; index restarts whenever the stream pauses.
module tapcal_pattern_gen #(
  parameter int GROUPS = 256,  // 2..256
  parameter int WORD_W = 32,
  parameter int IDX_W  = $clog2(GROUPS) + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [WORD_W-1:0] word_o,
  output logic              last_o
);
  localparam int GRP_W = IDX_W - 2;
  localparam int HALF  = WORD_W / 2;

  logic [IDX_W-1:0] idx_q;
  logic [7:0]       grp;
  logic [1:0]       sub;
  logic             lo_bit, hi_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (adv_i) idx_q <= idx_q + IDX_W'(1);
    else            idx_q <= '0;
  end

  always_comb begin
    grp = '0;
    grp[GRP_W-1:0] = idx_q[IDX_W-1:2];
    sub    = idx_q[1:0];
    lo_bit = grp[{sub, 1'b0}];
    hi_bit = grp[{sub, 1'b1}];
  end

  assign word_o = {{HALF{hi_bit}}, {HALF{lo_bit}}};
  assign idx_o  = idx_q;
  assign last_o = &idx_q;

endmodule

// File: rtl/tapcal_midpoint.sv
module tapcal_midpoint #(
  parameter int TAP_W = 6
) (
  input  logic [TAP_W:0]   upper_i,
  input  logic [TAP_W:0]   lower_i,
  output logic [TAP_W-1:0] mid_o,
  output logic [TAP_W-1:0] mid_p1_o
);
  logic [TAP_W+1:0] sum;
  logic [TAP_W+1:0] half;

  always_comb begin
    sum  = {1'b0, upper_i} + {1'b0, lower_i};
    half = sum >> 1;
    mid_o = half[TAP_W-1:0];
    // lane 1 saturates at the top tap
    mid_p1_o = (&mid_o) ? mid_o : mid_o + TAP_W'(1);
  end

endmodule

// File: rtl/tapcal_seq.sv
module tapcal_seq
  import tapcal_pkg::*;
#(
  parameter int TAP_W      = 6,
  parameter int TAP_CEIL   = 32,
  parameter int SETTLE_CYC = 4,
  parameter int PASSES     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TAP_W-1:0] init_tap_i,
  input  logic             test_ack_i,
  input  logic             test_fail_i,
  input  logic             last_word_i,
  output logic [TAP_W-1:0] tap_o,
  output logic [TAP_W:0]   upper_o,
  output logic [TAP_W:0]   lower_o,
  output logic             busy_o,
  output logic             stream_o,
  output logic             test_req_o,
  output logic             fin_o
);
  localparam int SCNT_W = $clog2(SETTLE_CYC + 1);
  localparam int PASS_W = (PASSES > 1) ? $clog2(PASSES) : 1;
  localparam logic [SCNT_W-1:0] SCNT_LAST = SCNT_W'(SETTLE_CYC - 1);
  localparam logic [PASS_W-1:0] PASS_LAST = PASS_W'(PASSES - 1);
  localparam logic [TAP_W-1:0]  CEIL      = TAP_W'(TAP_CEIL);

  cal_state_e        state_q;
  logic [TAP_W-1:0]  tap_q, init_q;
  logic [TAP_W:0]    upper_q, lower_q;
  logic [SCNT_W-1:0] scnt_q;
  logic [PASS_W-1:0] pass_q;
  logic              up_q, fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tap_q   <= '0;
      init_q  <= '0;
      upper_q <= '0;
      lower_q <= '0;
      scnt_q  <= '0;
      pass_q  <= '0;
      up_q    <= 1'b1;
      fail_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            tap_q   <= init_tap_i;
            init_q  <= init_tap_i;
            up_q    <= 1'b1;
            scnt_q  <= '0;
            pass_q  <= '0;
            state_q <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (scnt_q == SCNT_LAST) begin
            scnt_q  <= '0;
            state_q <= ST_STREAM;
          end else begin
            scnt_q <= scnt_q + SCNT_W'(1);
          end
        end
        ST_STREAM: begin
          if (last_word_i) state_q <= ST_REQ;
        end
        ST_REQ: begin
          if (test_ack_i) begin
            if (test_fail_i || pass_q == PASS_LAST) begin
              fail_q  <= test_fail_i;
              pass_q  <= '0;
              state_q <= ST_EVAL;
            end else begin
              pass_q  <= pass_q + PASS_W'(1);
              state_q <= ST_STREAM;
            end
          end
        end
        ST_EVAL: begin
          if (up_q) begin
            if (fail_q) begin
              upper_q <= (tap_q == '0) ? '0 : {1'b0, tap_q} - (TAP_W+1)'(1);
              up_q    <= 1'b0;
              tap_q   <= init_q;
            end else if (tap_q < CEIL) begin
              tap_q <= tap_q + TAP_W'(1);
            end else begin
              upper_q <= {1'b0, tap_q};
              up_q    <= 1'b0;
              tap_q   <= init_q;
            end
            state_q <= ST_SETTLE;
          end else begin
            if (fail_q) begin
              lower_q <= {1'b0, tap_q} + (TAP_W+1)'(1);
              state_q <= ST_FINAL;
            end else if (tap_q == '0) begin
              lower_q <= '0;
              state_q <= ST_FINAL;
            end else begin
              tap_q   <= tap_q - TAP_W'(1);
              state_q <= ST_SETTLE;
            end
          end
        end
        ST_FINAL: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign tap_o      = tap_q;
  assign upper_o    = upper_q;
  assign lower_o    = lower_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign stream_o   = (state_q == ST_STREAM);
  assign test_req_o = (state_q == ST_REQ);
  assign fin_o      = (state_q == ST_FINAL);

endmodule

// File: rtl/tapcal_engine.sv
module tapcal_engine #(
  parameter int TAP_W      = 6,
  parameter int TAP_CEIL   = 32,
  parameter int SETTLE_CYC = 4,
  parameter int PASSES     = 2,
  parameter int GROUPS     = 256,
  parameter int WORD_W     = 32,
  localparam int IDX_W     = $clog2(GROUPS) + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TAP_W-1:0]  init_tap_i,
  output logic [TAP_W-1:0]  lane0_tap_o,
  output logic [TAP_W-1:0]  lane1_tap_o,
  output logic              test_req_o,
  input  logic              test_ack_i,
  input  logic              test_fail_i,
  output logic              pat_valid_o,
  output logic [IDX_W-1:0]  pat_idx_o,
  output logic [WORD_W-1:0] pat_word_o,
  output logic              done_o
);
  logic [TAP_W-1:0] trial_tap, mid, mid_p1, fin0_q, fin1_q;
  logic [TAP_W:0]   upper, lower;
  logic             busy, stream, last_word, fin, done_q;

  tapcal_seq #(
    .TAP_W(TAP_W), .TAP_CEIL(TAP_CEIL), .SETTLE_CYC(SETTLE_CYC), .PASSES(PASSES)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .init_tap_i(init_tap_i),
    .test_ack_i(test_ack_i), .test_fail_i(test_fail_i), .last_word_i(last_word),
    .tap_o(trial_tap), .upper_o(upper), .lower_o(lower), .busy_o(busy),
    .stream_o(stream), .test_req_o(test_req_o), .fin_o(fin)
  );

  tapcal_pattern_gen #(
    .GROUPS(GROUPS), .WORD_W(WORD_W), .IDX_W(IDX_W)
  ) u_pat (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(stream),
    .idx_o(pat_idx_o), .word_o(pat_word_o), .last_o(last_word)
  );

  tapcal_midpoint #(.TAP_W(TAP_W)) u_mid (
    .upper_i(upper), .lower_i(lower), .mid_o(mid), .mid_p1_o(mid_p1)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fin0_q <= '0;
      fin1_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin;
      if (fin) begin
        fin0_q <= mid;
        fin1_q <= mid_p1;
      end
    end
  end

  // trial tap on both lanes while busy, centred result otherwise
  assign lane0_tap_o = busy ? trial_tap : fin0_q;
  assign lane1_tap_o = busy ? trial_tap : fin1_q;
  assign pat_valid_o = stream;
  assign done_o      = done_q;

endmodule

// File: rtl/tapcal_engine_chk.sv
module tapcal_engine_chk #(
  parameter int TAP_W      = 6,
  parameter int SETTLE_CYC = 4,
  parameter int IDX_W      = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [TAP_W-1:0] lane0_tap_o,
  input logic [TAP_W-1:0] lane1_tap_o,
  input logic             test_req_o,
  input logic             test_ack_i,
  input logic             pat_valid_o,
  input logic [IDX_W-1:0] pat_idx_o,
  input logic             done_o,
  input logic             busy
);
  logic [TAP_W-1:0] prev_lane_q;
  logic [3:0]       chg_cnt_q;

  // cycles since lane 0 last changed, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_lane_q <= '0;
      chg_cnt_q   <= '0;
    end else begin
      prev_lane_q <= lane0_tap_o;
      if (lane0_tap_o != prev_lane_q) chg_cnt_q <= 4'd1;
      else if (chg_cnt_q != 4'hf)     chg_cnt_q <= chg_cnt_q + 4'd1;
    end
  end

  assert_lanes_equal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pat_valid_o || test_req_o) |-> (lane0_tap_o == lane1_tap_o));

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_lane1_offset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lane1_tap_o == ((&lane0_tap_o) ? lane0_tap_o : lane0_tap_o + TAP_W'(1))));

  assert_idx_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pat_valid_o && $past(pat_valid_o)) |-> (pat_idx_o == $past(pat_idx_o) + IDX_W'(1)));

  assert_stream_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pat_valid_o) |-> (pat_idx_o == '0));

  assert_settle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pat_valid_o) |-> (chg_cnt_q >= 4'(SETTLE_CYC)));

  assert_req_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_req_o && !test_ack_i) |=> test_req_o);

  assert_final_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && $past(!busy)) |-> ($stable(lane0_tap_o) && $stable(lane1_tap_o)));

endmodule

bind tapcal_engine tapcal_engine_chk #(
  .TAP_W(TAP_W), .SETTLE_CYC(SETTLE_CYC), .IDX_W(IDX_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lane0_tap_o(lane0_tap_o), .lane1_tap_o(lane1_tap_o),
  .test_req_o(test_req_o), .test_ack_i(test_ack_i), .pat_valid_o(pat_valid_o),
  .pat_idx_o(pat_idx_o), .done_o(done_o), .busy(busy)
);

// File: tb/tapcal_engine_test.sv
`timescale 1ns/1ps
module tapcal_engine_test;
  localparam int GROUPS = 4;
  localparam int WORDS  = 4 * GROUPS;
  localparam int IDX_W  = $clog2(GROUPS) + 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  init_tap_i = '0;
  logic [5:0]  lane0_tap_o, lane1_tap_o;
  logic        test_req_o;
  logic        test_ack_i = 1'b0;
  logic        test_fail_i = 1'b0;
  logic        pat_valid_o;
  logic [IDX_W-1:0] pat_idx_o;
  logic [31:0] pat_word_o;
  logic        done_o;

  always #2 clk_i = ~clk_i;

  tapcal_engine #(.GROUPS(GROUPS)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .init_tap_i(init_tap_i),
    .lane0_tap_o(lane0_tap_o), .lane1_tap_o(lane1_tap_o), .test_req_o(test_req_o),
    .test_ack_i(test_ack_i), .test_fail_i(test_fail_i), .pat_valid_o(pat_valid_o),
    .pat_idx_o(pat_idx_o), .pat_word_o(pat_word_o), .done_o(done_o)
  );

  int checks = 0;
  int errors = 0;

  // checker model of the memory: pass window and an optional second-pass failure
  int win_lo, win_hi, second_fail_tap;
  int pidx;
  int log_tap[256];
  int log_n;
  int stream_err, settle_err, lane_err;

  int exp_seq[256];
  int exp_n, exp_l0, exp_l1;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit verdict_fail(int tap, int p);
    return !(tap >= win_lo && tap <= win_hi) || (p == 1 && tap == second_fail_tap);
  endfunction

  // responder: verdict two cycles after a request
  initial begin
    forever begin
      @(negedge clk_i);
      if (test_req_o && !test_ack_i) begin
        repeat (2) @(negedge clk_i);
        test_fail_i = verdict_fail(int'(lane0_tap_o), pidx);
        test_ack_i  = 1'b1;
        if (log_n < 256) log_tap[log_n] = int'(lane0_tap_o);
        log_n++;
        pidx = (pidx == 0 && !test_fail_i) ? 1 : 0;
        @(negedge clk_i);
        test_ack_i  = 1'b0;
        test_fail_i = 1'b0;
      end
    end
  end

  // stream, settle and lane monitors
  logic [5:0] mon_prev_lane = '0;
  int mon_cnt = 0;
  bit mon_prev_valid = 0;
  int mon_prev_idx = 0;
  int mon_words = 0;
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni) begin
        if (lane0_tap_o != mon_prev_lane) mon_cnt = 0;
        else mon_cnt++;
        mon_prev_lane = lane0_tap_o;
        if ((pat_valid_o || test_req_o) && lane0_tap_o != lane1_tap_o) lane_err++;
        if (pat_valid_o) begin
          int n, g, k;
          logic [31:0] w;
          n = int'(pat_idx_o);
          g = n / 4;
          k = n % 4;
          w[15:0]  = ((g >> (2*k)) & 1) != 0 ? 16'hffff : 16'h0000;
          w[31:16] = ((g >> (2*k+1)) & 1) != 0 ? 16'hffff : 16'h0000;
          if (pat_word_o != w) stream_err++;
          if (mon_prev_valid ? (n != mon_prev_idx + 1) : (n != 0)) stream_err++;
          if (!mon_prev_valid && mon_cnt < 4 && lane0_tap_o != uut.u_chk.prev_lane_q) settle_err++;
          if (!mon_prev_valid && mon_cnt < 4) settle_err++;
          mon_words++;
          mon_prev_idx = n;
        end else if (mon_prev_valid) begin
          if (mon_words != WORDS) stream_err++;
          mon_words = 0;
        end
        mon_prev_valid = pat_valid_o;
      end
    end
  end

  task automatic model(int init);
    int t, upper, lower;
    bit up, fin, fail;
    exp_n = 0; t = init; up = 1; fin = 0; upper = 0; lower = 0;
    while (!fin && exp_n < 250) begin
      fail = 0;
      for (int p = 0; p < 2; p++) begin
        exp_seq[exp_n] = t;
        exp_n++;
        if (verdict_fail(t, p)) begin fail = 1; break; end
      end
      if (up) begin
        if (fail) begin upper = (t == 0) ? 0 : t - 1; up = 0; t = init; end
        else if (t < 32) t++;
        else begin upper = t; up = 0; t = init; end
      end else begin
        if (fail) begin lower = t + 1; fin = 1; end
        else if (t == 0) begin lower = 0; fin = 1; end
        else t--;
      end
    end
    exp_l0 = (upper + lower) / 2;
    exp_l1 = (exp_l0 == 63) ? 63 : exp_l0 + 1;
  endtask

  task automatic run_case(string tag, int init, int lo, int hi, int sf, bit poke);
    bit seen;
    int mism;
    logic [5:0] h0, h1;
    win_lo = lo; win_hi = hi; second_fail_tap = sf;
    model(init);
    pidx = 0; log_n = 0; stream_err = 0; settle_err = 0; lane_err = 0;
    @(negedge clk_i);
    start_i = 1'b1; init_tap_i = 6'(init);
    @(negedge clk_i);
    start_i = 1'b0;
    if (poke) begin
      repeat (30) @(negedge clk_i);
      start_i = 1'b1; init_tap_i = 6'd50;
      @(negedge clk_i);
      start_i = 1'b0; init_tap_i = 6'd0;
    end
    seen = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk_i);
      if (done_o) begin seen = 1; break; end
    end
    chk({tag, " R5 done seen"}, int'(seen), 1);
    chk({tag, " R5 lane0 centre"}, int'(lane0_tap_o), exp_l0);
    chk({tag, " R5 lane1 centre+1"}, int'(lane1_tap_o), exp_l1);
    chk({tag, " trial count"}, log_n, exp_n);
    mism = 0;
    for (int i = 0; i < exp_n && i < log_n; i++) if (log_tap[i] != exp_seq[i]) mism++;
    chk({tag, " trial tap order"}, mism, 0);
    chk({tag, " R7 pattern stream"}, stream_err, 0);
    chk({tag, " R8 settle"}, settle_err, 0);
    chk({tag, " R1 lanes equal"}, lane_err, 0);
    h0 = lane0_tap_o; h1 = lane1_tap_o;
    @(negedge clk_i);
    chk({tag, " R5 done one cycle"}, int'(done_o), 0);
    repeat (20) @(negedge clk_i);
    chk({tag, " R10 lane0 held"}, int'(lane0_tap_o), int'(h0));
    chk({tag, " R10 lane1 held"}, int'(lane1_tap_o), int'(h1));
  endtask

  task automatic test_reset();
    chk("R10 reset lane0", int'(lane0_tap_o), 0);
    chk("R10 reset lane1", int'(lane1_tap_o), 0);
    chk("R10 reset done", int'(done_o), 0);
    chk("R10 reset req", int'(test_req_o), 0);
    chk("R10 reset valid", int'(pat_valid_o), 0);
  endtask

  // R3 upward failure at 21, R4 downward failure at 5: centre 13/14
  task automatic test_both_fail();
    run_case("R3/R4 window", 10, 6, 20, -1, 0);
    chk("R3 centre lane0", exp_l0, 13);
  endtask

  // R2 ceiling reached at 32 with no failure
  task automatic test_ceiling();
    run_case("R2 ceiling", 28, 3, 40, -1, 0);
    chk("R2 centre lane0", exp_l0, 17);
  endtask

  // R4 tap 0 passes
  task automatic test_floor();
    run_case("R4 floor", 4, 0, 9, -1, 0);
    chk("R4 centre lane0", exp_l0, 4);
  endtask

  // R6 failure only on the second pass at tap 14
  task automatic test_second_pass();
    int reqs14;
    run_case("R6 second pass", 10, 0, 63, 14, 0);
    reqs14 = 0;
    for (int i = 0; i < log_n; i++) if (log_tap[i] == 14) reqs14++;
    chk("R6 two requests at failing tap", reqs14, 2);
    chk("R6 centre lane0", int'(lane0_tap_o), 6);
  endtask

  // R9 second start mid-run must be ignored
  task automatic test_start_ignored();
    run_case("R9 busy start", 10, 6, 20, -1, 1);
    chk("R9 result unchanged", int'(lane0_tap_o), 13);
  endtask

  // R5 saturation of lane 1 at 63
  task automatic test_saturate();
    run_case("R5 saturate", 63, 63, 63, -1, 0);
    chk("R5 lane1 saturated", int'(lane1_tap_o), 63);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    test_reset();
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    test_both_fail();
    test_ceiling();
    test_floor();
    test_second_pass();
    test_start_ignored();
    test_saturate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule